// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. It sets the timing of each conversion and holds the flags and result that software sees. A 4-bit timing code picks three phase lengths, counted in base clock periods: the sample window, the comparison window and a trailing extra window. The comparison window is split evenly into ten bit decisions, taken from the MSB down. At each decision the block drives a trial code to the capacitor array and reads back one comparator bit.

After every reset the block starts a long self-calibration with the busy flag already high. When calibration finishes, the completion interrupt flag is raised in the same way as at the end of a conversion. Each accepted start latches the timing code, the channel number and the port-select bit, so a later change on those inputs has no effect on the conversion in progress. A separate power-off input blocks new starts and is passed through to the analog section. When the alternate port is selected, only channel bits [2:0] are used.

Top module: `adc_seq_ctrl`

## Requirements
- R1: From reset, `busy_o` is 1 and `irq_o` is 0. `busy_o` stays high for exactly CAL_CYCLES clock cycles after reset is released. In the cycle it falls, `irq_o` becomes 1 and `result_o` keeps its reset value of 0.
- R2: A start accepted while idle raises `busy_o` at the next edge. `busy_o` then stays high for exactly sample+comparison+extra cycles of the timing code latched at that start. The phase lengths (sample/comparison/extra) are: 0000 120/240/28, 0001 140/280/16, 0010 200/280/52, 0011 400/280/44, 1100 240/120/52, 1101 280/560/28, 1110 400/560/100, 1111 800/560/52, 1000 480/960/100, 1001 560/1120/52, 1010 800/1120/196, 1011 1600/1120/164.
- R3: A timing code of the form 01xx selects the 0000 timing, which gives a total of 388 cycles.
- R4: `sampling_o` is high during exactly the first sample-length cycles of each conversion and is low at all other times.
- R5: The comparison phase is made of ten equal steps of comparison/10 cycles each. In the first comparison cycle, `dac_o` is 10'h200. At the last cycle of each step, the bit under trial is kept if `cmp_i` is 1 (the input is at or above `dac_o`) and cleared if it is 0, and the next lower bit is then set. With an ideal comparator, the final code is the binary value of the input.
- R6: `result_o` and `result_ch_o` load at the edge where `busy_o` falls after a conversion, and `irq_o` sets at that same edge. At all other edges `result_o` keeps its value.
- R7: A start request made while `busy_o` is high is ignored, and the conversion length does not change.
- R8: While `adc_off_i` is 1, a start request is ignored and `busy_o` stays 0. `pwr_dn_o` follows `adc_off_i`.
- R9: With `port_alt_i` at 0, all four channel bits pass to `mux_ch_o` and `result_ch_o`. With `port_alt_i` at 1, bit 3 is forced to 0 on both outputs, and `mux_alt_o` is 1 from the start until the next start.
- R10: `irq_o` stays set until `ack_i` is sampled high, after which it clears at the next edge. If a completion and `ack_i` occur in the same cycle, the set wins.
- R11: Changing `tcode_i`, `ch_i` or `port_alt_i` during a conversion changes neither its length nor its result channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion start request |
| tcode_i | input | 4 | Timing code |
| ch_i | input | CH_W | Requested channel number |
| port_alt_i | input | 1 | 0: primary port, 1: alternate port |
| adc_off_i | input | 1 | Analog power-off / disable |
| ack_i | input | 1 | Result read strobe, clears `irq_o` |
| cmp_i | input | 1 | Comparator: input at or above `dac_o` |
| busy_o | output | 1 | Calibration or conversion in progress |
| irq_o | output | 1 | Conversion-complete flag |
| sampling_o | output | 1 | Sample switch closed |
| dac_o | output | RES_W | Trial code to capacitor array |
| mux_ch_o | output | CH_W | Channel held for the conversion |
| mux_alt_o | output | 1 | Port held for the conversion |
| pwr_dn_o | output | 1 | Analog section powered down |
| result_o | output | RES_W | Last conversion result |
| result_ch_o | output | CH_W | Channel of last result |

## Verification
The hardest case to reach from the ports is a completion and an acknowledge that land on the same edge, because the completion edge lies hundreds of cycles after the start. The bench reaches it by holding `ack_i` high for the whole of one conversion. It then expects `irq_o` to be seen set just after `busy_o` falls and to be cleared one cycle later. The bench models the comparator as an ideal compare between a chosen input value and `dac_o`. For each timing code, it counts the cycles of `busy_o` and `sampling_o` against its own phase table.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int PH_W = 11;

    typedef logic [PH_W-1:0] ph_len_t;

    // step = comparison length divided by the ten bit decisions
    typedef struct packed {
        ph_len_t smp;
        ph_len_t step;
        ph_len_t ext;
    } phase_set_t;

    typedef enum logic [2:0] {
        ST_CAL,
        ST_IDLE,
        ST_SMP,
        ST_CMP,
        ST_EXT
    } seq_st_t;

    function automatic phase_set_t code_to_phases(input logic [3:0] code);
        phase_set_t p;
        case (code)
            4'b0001: p = '{smp: 11'd140,  step: 11'd28,  ext: 11'd16};
            4'b0010: p = '{smp: 11'd200,  step: 11'd28,  ext: 11'd52};
            4'b0011: p = '{smp: 11'd400,  step: 11'd28,  ext: 11'd44};
            4'b1100: p = '{smp: 11'd240,  step: 11'd12,  ext: 11'd52};
            4'b1101: p = '{smp: 11'd280,  step: 11'd56,  ext: 11'd28};
            4'b1110: p = '{smp: 11'd400,  step: 11'd56,  ext: 11'd100};
            4'b1111: p = '{smp: 11'd800,  step: 11'd56,  ext: 11'd52};
            4'b1000: p = '{smp: 11'd480,  step: 11'd96,  ext: 11'd100};
            4'b1001: p = '{smp: 11'd560,  step: 11'd112, ext: 11'd52};
            4'b1010: p = '{smp: 11'd800,  step: 11'd112, ext: 11'd196};
            4'b1011: p = '{smp: 11'd1600, step: 11'd112, ext: 11'd164};
            default: p = '{smp: 11'd120,  step: 11'd24,  ext: 11'd28};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/adc_seq_tmap.sv
module adc_seq_tmap
    import adc_seq_pkg::*;
(
    input  logic [3:0]  code_i,
    output phase_set_t  phases_o
);
    // reserved 01xx codes fall through to the 0000 timing in the default arm
    always_comb begin
        phases_o = code_to_phases(code_i);
    end
endmodule

// File: rtl/adc_seq_chsel.sv
module adc_seq_chsel #(
    parameter int CH_W  = 4,
    parameter int ALT_W = 3
) (
    input  logic [CH_W-1:0] ch_i,
    input  logic            alt_i,
    output logic [CH_W-1:0] ch_o
);
    localparam logic [CH_W-1:0] ALT_MASK = CH_W'((1 << ALT_W) - 1);

    generate
        if (ALT_W >= CH_W) begin : g_full
            always_comb ch_o = ch_i;
        end else begin : g_mask
            always_comb ch_o = alt_i ? (ch_i & ALT_MASK) : ch_i;
        end
    endgenerate
endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] code_o,
    output logic             last_o
);
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        logic [RES_W-1:0] sar;
        logic [RES_W-1:0] ptr;
    } sar_regs_t;

    sar_regs_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.sar = MSB_ONLY;
            d.ptr = MSB_ONLY;
        end else if (step_i) begin
            d.sar = cmp_i ? q.sar : (q.sar & ~q.ptr);
            d.ptr = q.ptr >> 1;
            d.sar = d.sar | d.ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign code_o = q.sar;
    assign last_o = q.ptr[0];

    // R5: a fresh comparison begins with only the MSB on trial
    a_r5_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (code_o == MSB_ONLY));

    // R5: each decision leaves the bits above the trial bit untouched
    a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !cmp_i) |=> (code_o[RES_W-1] == $past(code_o[RES_W-1]) || $past(last_o) || $past(code_o) == MSB_ONLY));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int CH_W       = 4,
    parameter int ALT_W      = 3,
    parameter int CAL_CYCLES = 40629
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       tcode_i,
    input  logic [CH_W-1:0]  ch_i,
    input  logic             port_alt_i,
    input  logic             adc_off_i,
    input  logic             ack_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic             irq_o,
    output logic             sampling_o,
    output logic [RES_W-1:0] dac_o,
    output logic [CH_W-1:0]  mux_ch_o,
    output logic             mux_alt_o,
    output logic             pwr_dn_o,
    output logic [RES_W-1:0] result_o,
    output logic [CH_W-1:0]  result_ch_o
);
    localparam int CAL_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
    localparam logic [CAL_W-1:0] CAL_LAST = CAL_W'(CAL_CYCLES - 1);

    typedef struct packed {
        seq_st_t          st;
        ph_len_t          cnt;
        logic [CAL_W-1:0] cal;
        phase_set_t       ph;
        logic [CH_W-1:0]  ch;
        logic             alt;
        logic             irq;
        logic [RES_W-1:0] res;
        logic [CH_W-1:0]  res_ch;
    } ctl_regs_t;

    ctl_regs_t q, d;

    phase_set_t       ph_sel;
    logic [CH_W-1:0]  ch_masked;
    logic [RES_W-1:0] sar_code;
    logic             sar_last;
    logic             sar_load;
    logic             sar_step;
    logic             done;

    adc_seq_tmap u_tmap (
        .code_i   (tcode_i),
        .phases_o (ph_sel)
    );

    adc_seq_chsel #(.CH_W(CH_W), .ALT_W(ALT_W)) u_chsel (
        .ch_i  (ch_i),
        .alt_i (port_alt_i),
        .ch_o  (ch_masked)
    );

    adc_seq_sar #(.RES_W(RES_W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sar_load),
        .step_i (sar_step),
        .cmp_i  (cmp_i),
        .code_o (sar_code),
        .last_o (sar_last)
    );

    always_comb begin
        d        = q;
        sar_load = 1'b0;
        sar_step = 1'b0;
        done     = 1'b0;
        case (q.st)
            ST_CAL: begin
                if (q.cal == CAL_LAST) begin
                    d.st = ST_IDLE;
                    done = 1'b1;
                end else begin
                    d.cal = q.cal + 1'b1;
                end
            end
            ST_IDLE: begin
                if (start_i && !adc_off_i) begin
                    d.st  = ST_SMP;
                    d.cnt = '0;
                    d.ph  = ph_sel;
                    d.ch  = ch_masked;
                    d.alt = port_alt_i;
                end
            end
            ST_SMP: begin
                if (q.cnt == q.ph.smp - 1'b1) begin
                    d.st     = ST_CMP;
                    d.cnt    = '0;
                    sar_load = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_CMP: begin
                if (q.cnt == q.ph.step - 1'b1) begin
                    sar_step = 1'b1;
                    d.cnt    = '0;
                    if (sar_last) d.st = ST_EXT;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_EXT: begin
                if (q.cnt == q.ph.ext - 1'b1) begin
                    d.st     = ST_IDLE;
                    d.res    = sar_code;
                    d.res_ch = q.ch;
                    done     = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (done)       d.irq = 1'b1;
        else if (ack_i) d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_CAL;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.st != ST_IDLE);
    assign irq_o       = q.irq;
    assign sampling_o  = (q.st == ST_SMP);
    assign dac_o       = sar_code;
    assign mux_ch_o    = q.ch;
    assign mux_alt_o   = q.alt;
    assign pwr_dn_o    = adc_off_i;
    assign result_o    = q.res;
    assign result_ch_o = q.res_ch;

    // R6: completion flag rises with the end of busy
    a_r6_irq_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> irq_o);

    // R6: the result only moves on the completion edge
    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy_o) |-> $stable(result_o));

    // R7: nothing but completion ends a running sequence
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done) |=> busy_o);

    // R8: power-off keeps the idle sequencer idle
    a_r8_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && adc_off_i) |=> !busy_o);

    // R9: alternate port never presents an upper channel bit
    a_r9_alt_mask: assert property (@(posedge clk) disable iff (!rst_n)
        mux_alt_o |-> (mux_ch_o[CH_W-1] == 1'b0));

    // R10: flag is sticky until acknowledged
    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> irq_o);

    // R10: acknowledge clears unless a completion coincides
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !done) |=> !irq_o);
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int RES_W = 10;
    localparam int CH_W  = 4;
    localparam int CAL   = 300;
    localparam int NVEC  = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [3:0]       tcode_i = 4'b0000;
    logic [CH_W-1:0]  ch_i = '0;
    logic             port_alt_i = 1'b0;
    logic             adc_off_i = 1'b0;
    logic             ack_i = 1'b0;
    logic             cmp_i;
    logic             busy_o, irq_o, sampling_o, mux_alt_o, pwr_dn_o;
    logic [RES_W-1:0] dac_o, result_o;
    logic [CH_W-1:0]  mux_ch_o, result_ch_o;
    logic [RES_W-1:0] vin = '0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    // ideal comparator: high when the input is at or above the trial code
    assign cmp_i = (vin >= dac_o);

    adc_seq_ctrl #(.RES_W(RES_W), .CH_W(CH_W), .ALT_W(3), .CAL_CYCLES(CAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tcode_i(tcode_i),
        .ch_i(ch_i), .port_alt_i(port_alt_i), .adc_off_i(adc_off_i),
        .ack_i(ack_i), .cmp_i(cmp_i), .busy_o(busy_o), .irq_o(irq_o),
        .sampling_o(sampling_o), .dac_o(dac_o), .mux_ch_o(mux_ch_o),
        .mux_alt_o(mux_alt_o), .pwr_dn_o(pwr_dn_o), .result_o(result_o),
        .result_ch_o(result_ch_o)
    );

    // {tcode, channel, alt, input}
    localparam logic [18:0] VEC [NVEC] = '{
        {4'b0000, 4'd5,  1'b0, 10'd0},
        {4'b0001, 4'd15, 1'b0, 10'd1023},
        {4'b0010, 4'd13, 1'b1, 10'd512},
        {4'b0011, 4'd2,  1'b0, 10'd511},
        {4'b1100, 4'd9,  1'b1, 10'd341},
        {4'b1101, 4'd7,  1'b0, 10'd682},
        {4'b1110, 4'd8,  1'b0, 10'd1},
        {4'b1111, 4'd14, 1'b1, 10'd1022},
        {4'b1000, 4'd3,  1'b0, 10'd100},
        {4'b1001, 4'd11, 1'b0, 10'd777},
        {4'b1010, 4'd6,  1'b1, 10'd5},
        {4'b1011, 4'd12, 1'b0, 10'd900},
        {4'b0100, 4'd1,  1'b0, 10'd300},
        {4'b0111, 4'd10, 1'b1, 10'd618}
    };

    function automatic int exp_total(input logic [3:0] c);
        case (c)
            4'b0001: return 436;  4'b0010: return 532;  4'b0011: return 724;
            4'b1100: return 412;  4'b1101: return 868;  4'b1110: return 1060;
            4'b1111: return 1412; 4'b1000: return 1540; 4'b1001: return 1732;
            4'b1010: return 2116; 4'b1011: return 2884;
            default: return 388;
        endcase
    endfunction

    function automatic int exp_smp(input logic [3:0] c);
        case (c)
            4'b0001: return 140;  4'b0010: return 200;  4'b0011: return 400;
            4'b1100: return 240;  4'b1101: return 280;  4'b1110: return 400;
            4'b1111: return 800;  4'b1000: return 480;  4'b1001: return 560;
            4'b1010: return 800;  4'b1011: return 1600;
            default: return 120;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // pulse start, then count busy and sampling cycles; optional mid-run disturbance
    task automatic run_conv(input logic [3:0] tc, input logic [CH_W-1:0] ch,
                            input logic alt, input bit disturb,
                            output int nbusy, output int nsmp, output int dac_first);
        @(negedge clk);
        tcode_i = tc; ch_i = ch; port_alt_i = alt; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        nbusy = 0; nsmp = 0; dac_first = -1;
        while (busy_o) begin
            nbusy++;
            if (sampling_o) nsmp++;
            if (nbusy == exp_smp(tc) + 1) dac_first = int'(dac_o);
            if (disturb && nbusy == 50) begin
                start_i = 1'b1; tcode_i = 4'b1011; ch_i = ~ch; port_alt_i = ~alt;
            end
            if (disturb && nbusy == 51) start_i = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int nb, ns, df, n;
        logic [CH_W-1:0] ech;

        // R1: reset state and calibration length
        @(negedge clk);
        chk(busy_o === 1'b1, "R1 busy in reset", int'(busy_o), 1);
        chk(irq_o === 1'b0, "R1 irq in reset", int'(irq_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        while (busy_o) begin n++; @(negedge clk); end
        chk(n == CAL, "R1 calibration length", n, CAL);
        chk(irq_o === 1'b1, "R1 irq after calibration", int'(irq_o), 1);
        chk(result_o == '0, "R1 result after calibration", int'(result_o), 0);
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
        chk(irq_o === 1'b0, "R10 ack clears calibration irq", int'(irq_o), 0);

        // R2 R3 R4 R5 R6 R9: vector table
        for (int i = 0; i < NVEC; i++) begin
            vin = VEC[i][9:0];
            ech = VEC[i][10] ? (VEC[i][14:11] & 4'b0111) : VEC[i][14:11];
            run_conv(VEC[i][18:15], VEC[i][14:11], VEC[i][10], 1'b0, nb, ns, df);
            chk(nb == exp_total(VEC[i][18:15]), "R2/R3 busy length", nb, exp_total(VEC[i][18:15]));
            chk(ns == exp_smp(VEC[i][18:15]), "R4 sample length", ns, exp_smp(VEC[i][18:15]));
            chk(df == 512, "R5 first trial code", df, 512);
            chk(result_o == vin, "R5 result code", int'(result_o), int'(vin));
            chk(result_ch_o == ech, "R9 result channel", int'(result_ch_o), int'(ech));
            chk(mux_alt_o == VEC[i][10], "R9 port held", int'(mux_alt_o), int'(VEC[i][10]));
            chk(irq_o === 1'b1, "R6 irq at completion", int'(irq_o), 1);
            @(negedge clk);
            chk(irq_o === 1'b1, "R10 irq sticky", int'(irq_o), 1);
            ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
            chk(irq_o === 1'b0, "R10 ack clears", int'(irq_o), 0);
        end

        // R7 R11: restart and input changes mid-conversion are ignored
        vin = 10'd444;
        run_conv(4'b0000, 4'd13, 1'b0, 1'b1, nb, ns, df);
        start_i = 1'b0; tcode_i = 4'b0000;
        chk(nb == 388, "R7 restart ignored length", nb, 388);
        chk(result_ch_o == 4'd13, "R11 channel unchanged", int'(result_ch_o), 13);
        chk(result_o == 10'd444, "R11 result", int'(result_o), 444);
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;

        // R10: completion wins over a coincident acknowledge
        ack_i = 1'b1;
        vin = 10'd33;
        run_conv(4'b0000, 4'd4, 1'b0, 1'b0, nb, ns, df);
        chk(irq_o === 1'b1, "R10 set wins over ack", int'(irq_o), 1);
        @(negedge clk);
        chk(irq_o === 1'b0, "R10 held ack clears next", int'(irq_o), 0);
        ack_i = 1'b0;

        // R8: power-off blocks start
        adc_off_i = 1'b1;
        @(negedge clk);
        chk(pwr_dn_o === 1'b1, "R8 power-down follows", int'(pwr_dn_o), 1);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        n = 0;
        for (int k = 0; k < 20; k++) begin
            if (busy_o) n++;
            @(negedge clk);
        end
        chk(n == 0, "R8 start ignored while off", n, 0);
        chk(result_o == 10'd33, "R8 result untouched", int'(result_o), 33);
        adc_off_i = 1'b0;
        @(negedge clk);
        chk(pwr_dn_o === 1'b0, "R8 power-down released", int'(pwr_dn_o), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule